// File: doc/BRIEF.md
# USB Endpoint Buffer Register Access Port

This block lets a CPU move packet data into and out of the endpoint buffers of a USB device controller through a few registers. A control register selects one logical endpoint and carries two enables, one for reading and one for writing. To send an IN packet, software sets the write enable, programs the byte count into the length register and then pushes 32-bit words into the transmit data register. The block stores each word at the next position in that endpoint's transmit buffer. When the last word has gone in, it drops the write enable itself and pulses a transmit end-of-packet flag. To read an OUT packet, software sets the read enable and pops words from the receive data register. After the final word the block drops the read enable, releases the buffer and pulses a receive end-of-packet flag.

Each endpoint keeps its own read and write word positions, so the two directions can be interleaved on one endpoint. If software withdraws an enable in the middle of a packet, the next access starts again at the first word. A finished transmit buffer becomes sendable only after a validate command arrives. For isochronous endpoints, a frame pulse decides what is sent and what is thrown away. The serial engine side is reduced to simple request/response ports: a packet request with an ack, nak and length reply, a word read port into the transmit buffer, and a word write port with a done strobe for received packets.

Top module: `usb_epbuf_port`

## Requirements
- R1: Register addresses are 0 control, 1 transmit length, 2 transmit data and 3 receive data. Control bit 0 is the read enable, bit 1 is the write enable and bits [2+:EPW] hold the endpoint number. A read returns its data on `reg_rdata` one cycle after `reg_rd`. After reset the control register reads 0 and all flags are low.
- R2: While the write enable is set, a write to the length register sets the packet byte count, clamped to 4*PKT_WORDS, and restarts at word 0. Each transmit data write stores the next word. The write that completes ceil(len/4) words, or a length write of 0, clears the write enable, and `tx_eop` is high for the one cycle that follows.
- R3: If the write enable is cleared, or the endpoint is changed while the write enable is set, the next transmit data write for that endpoint lands in word 0 again. The programmed length is kept.
- R4: While the read enable is set and the selected endpoint holds a packet, receive data reads return the stored words in order. In the final word only the remaining bytes are kept, little-endian from bit 0, and the other bytes are zero. The final read clears the read enable, frees the buffer and makes `rx_eop` high for the one cycle that follows.
- R5: If the read enable is cleared before the end of a packet, the packet stays in the buffer, and once the read enable is set again reading restarts at word 0.
- R6: Read and write enables may both be set on one endpoint. Interleaved reads and writes then advance independent positions.
- R7: `val_req` marks the transmit buffer of `val_ep` as validated. For a non-isochronous endpoint, `in_req` answers one cycle later with `in_ack` and `in_len` equal to the programmed length if the buffer is validated, and then clears the validation. Otherwise it answers with `in_nak`. `in_word` returns the transmit word at (`in_ep`, `in_word_idx`) one cycle after the address.
- R8: For an isochronous endpoint (a set bit in ISO_MASK, endpoint 3 by default), `in_req` always answers with `in_ack`. `in_len` is the programmed length only if the buffer was validated before the most recent `frame_tick`, which consumes the validation. Otherwise `in_len` is 0 and a later validation stays pending.
- R9: For a non-isochronous endpoint, `out_done` with a free buffer stores the packet with byte count `out_len`. While the buffer is still full, `out_wr` words are discarded and `out_done` gives an `out_nak` pulse one cycle later, with the old packet intact.
- R10: An isochronous receive buffer always accepts a new packet, which replaces unread data. `frame_tick` discards any unread isochronous packet.
- R11: With the matching enable low, a transmit data write changes no buffer content and no position, and a receive data read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | CPU register write strobe |
| reg_rd | input | 1 | CPU register read strobe (ignored when reg_wr is high) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | CPU write data |
| reg_rdata | output | 32 | CPU read data, one cycle after reg_rd |
| tx_eop | output | 1 | Transmit packet fully written (one-cycle pulse) |
| rx_eop | output | 1 | Receive packet fully read (one-cycle pulse) |
| frame_tick | input | 1 | Start-of-frame pulse |
| val_req | input | 1 | Validate-buffer command |
| val_ep | input | EPW | Endpoint for the validate command |
| in_req | input | 1 | Serial engine asks to send an IN packet |
| in_ep | input | EPW | Endpoint for in_req and in_word |
| in_word_idx | input | PTRW | Word index for the transmit buffer read |
| in_word | output | 32 | Transmit buffer word |
| in_ack | output | 1 | IN packet sent |
| in_nak | output | 1 | IN request refused, nothing validated |
| in_len | output | LENW | Bytes sent with in_ack |
| out_wr | input | 1 | Serial engine word write into the receive buffer |
| out_ep | input | EPW | Endpoint for out_wr and out_done |
| out_word_idx | input | PTRW | Word index for out_wr |
| out_wdata | input | 32 | Received word |
| out_done | input | 1 | Received packet complete |
| out_len | input | LENW | Byte count of the received packet |
| out_nak | output | 1 | Received packet refused (one-cycle pulse) |

## Verification
Every result here is one register stage away from its cause. Register read data, the two end-of-packet flags, `in_ack`/`in_nak`/`in_len` and `out_nak` all become valid on the clock edge that accepts the access or strobe. `in_word` follows its address by one edge. The bench drives each stimulus at a falling edge, removes it at the next falling edge and samples the result there, so every check lands in the single cycle in which the result is due. Single-cycle pulses are also checked to stay low after accesses that must not end a packet.

// File: rtl/usb_epbuf_pkg.sv
package usb_epbuf_pkg;

  typedef enum logic [1:0] {
    RA_CTRL   = 2'd0,
    RA_TXLEN  = 2'd1,
    RA_TXDATA = 2'd2,
    RA_RXDATA = 2'd3
  } reg_addr_e;

  // keep the low nb bytes of a word (nb >= 4 keeps all)
  function automatic logic [31:0] tail_mask(input logic [2:0] nb);
    case (nb)
      3'd0:    tail_mask = 32'h0000_0000;
      3'd1:    tail_mask = 32'h0000_00FF;
      3'd2:    tail_mask = 32'h0000_FFFF;
      3'd3:    tail_mask = 32'h00FF_FFFF;
      default: tail_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/usb_epbuf_ram.sv
module usb_epbuf_ram #(
  parameter int AW = 6,
  parameter int DW = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/usb_epbuf_tx.sv
module usb_epbuf_tx #(
  parameter int NUM_EP = 4,
  parameter int PKT_WORDS = 16,
  parameter logic [NUM_EP-1:0] ISO_MASK = NUM_EP'(1) << (NUM_EP - 1),
  localparam int EPW  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int PTRW = $clog2(PKT_WORDS),
  localparam int LENW = $clog2(PKT_WORDS * 4 + 1),
  localparam int MAXB = PKT_WORDS * 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [EPW-1:0]  ep_sel,
  input  logic            wr_en,
  input  logic            abort,
  input  logic            len_wr,
  input  logic            data_wr,
  input  logic [31:0]     wdata,
  output logic            done,
  output logic            tx_eop,
  input  logic            val_req,
  input  logic [EPW-1:0]  val_ep,
  input  logic            frame_tick,
  input  logic            in_req,
  input  logic [EPW-1:0]  in_ep,
  input  logic [PTRW-1:0] in_word_idx,
  output logic [31:0]     in_word,
  output logic            in_ack,
  output logic            in_nak,
  output logic [LENW-1:0] in_len
);
  logic [LENW-1:0] tx_len [NUM_EP];
  logic [PTRW-1:0] wr_ptr [NUM_EP];
  logic [NUM_EP-1:0] tx_valid, iso_arm;

  logic            len_acc, data_acc, last;
  logic [LENW-1:0] len_cl;
  logic [LENW:0]   next_bytes;

  always_comb begin
    len_acc    = len_wr && wr_en;
    data_acc   = data_wr && wr_en;
    len_cl     = (wdata > 32'(MAXB)) ? LENW'(MAXB) : wdata[LENW-1:0];
    next_bytes = (LENW+1)'({wr_ptr[ep_sel], 2'b00}) + (LENW+1)'(4);
    last       = next_bytes >= (LENW+1)'(tx_len[ep_sel]);
    done       = (len_acc && len_cl == '0) || (data_acc && last);
  end

  usb_epbuf_ram #(.AW(EPW + PTRW), .DW(32)) u_ram (
    .clk   (clk),
    .we    (data_acc),
    .waddr ({ep_sel, wr_ptr[ep_sel]}),
    .wdata (wdata),
    .raddr ({in_ep, in_word_idx}),
    .rdata (in_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < NUM_EP; e++) begin
        tx_len[e] <= '0;
        wr_ptr[e] <= '0;
      end
      tx_valid <= '0;
      iso_arm  <= '0;
      tx_eop   <= 1'b0;
      in_ack   <= 1'b0;
      in_nak   <= 1'b0;
      in_len   <= '0;
    end else begin
      tx_eop <= done;
      if (abort) wr_ptr[ep_sel] <= '0;
      if (len_acc) begin
        tx_len[ep_sel] <= len_cl;
        wr_ptr[ep_sel] <= '0;
      end
      if (data_acc) wr_ptr[ep_sel] <= last ? '0 : wr_ptr[ep_sel] + 1'b1;
      if (frame_tick) iso_arm <= tx_valid & ISO_MASK;
      in_ack <= 1'b0;
      in_nak <= 1'b0;
      in_len <= '0;
      if (in_req) begin
        if (ISO_MASK[in_ep]) begin
          in_ack <= 1'b1;
          if (iso_arm[in_ep]) begin
            in_len           <= tx_len[in_ep];
            iso_arm[in_ep]   <= 1'b0;
            tx_valid[in_ep]  <= 1'b0;
          end
        end else if (tx_valid[in_ep]) begin
          in_ack          <= 1'b1;
          in_len          <= tx_len[in_ep];
          tx_valid[in_ep] <= 1'b0;
        end else begin
          in_nak <= 1'b1;
        end
      end
      if (val_req) tx_valid[val_ep] <= 1'b1;
    end
  end

  a_r7_resp_needs_req: assert property (@(posedge clk) disable iff (rst)
    (in_ack || in_nak) |-> ($past(in_req) && !$past(rst)));
  a_r7_ack_nak_excl: assert property (@(posedge clk) disable iff (rst)
    !(in_ack && in_nak));
  a_r8_iso_never_nak: assert property (@(posedge clk) disable iff (rst)
    in_nak |-> !ISO_MASK[$past(in_ep)]);
endmodule

// File: rtl/usb_epbuf_rx.sv
module usb_epbuf_rx
  import usb_epbuf_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int PKT_WORDS = 16,
  parameter logic [NUM_EP-1:0] ISO_MASK = NUM_EP'(1) << (NUM_EP - 1),
  localparam int EPW  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int PTRW = $clog2(PKT_WORDS),
  localparam int LENW = $clog2(PKT_WORDS * 4 + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [EPW-1:0]  ep_sel,
  input  logic            rd_en,
  input  logic            abort,
  input  logic            data_rd,
  output logic            done,
  output logic            rx_eop,
  output logic            word_valid,
  output logic [31:0]     word,
  input  logic            frame_tick,
  input  logic            out_wr,
  input  logic [EPW-1:0]  out_ep,
  input  logic [PTRW-1:0] out_word_idx,
  input  logic [31:0]     out_wdata,
  input  logic            out_done,
  input  logic [LENW-1:0] out_len,
  output logic            out_nak
);
  logic [LENW-1:0]   rx_len [NUM_EP];
  logic [PTRW-1:0]   rd_ptr [NUM_EP];
  logic [NUM_EP-1:0] rx_full;

  logic          accept, hit, last;
  logic [LENW:0] done_bytes, rem;
  logic [2:0]    rem_nb;
  logic [31:0]   mask_q, ram_q;

  always_comb begin
    accept     = ISO_MASK[out_ep] || !rx_full[out_ep];
    hit        = data_rd && rd_en && rx_full[ep_sel];
    done_bytes = (LENW+1)'({rd_ptr[ep_sel], 2'b00});
    rem        = (LENW+1)'(rx_len[ep_sel]) - done_bytes;
    last       = (done_bytes + (LENW+1)'(4)) >= (LENW+1)'(rx_len[ep_sel]);
    rem_nb     = (rem >= (LENW+1)'(4)) ? 3'd4 : rem[2:0];
    done       = hit && last;
    word       = ram_q & mask_q;
  end

  usb_epbuf_ram #(.AW(EPW + PTRW), .DW(32)) u_ram (
    .clk   (clk),
    .we    (out_wr && accept),
    .waddr ({out_ep, out_word_idx}),
    .wdata (out_wdata),
    .raddr ({ep_sel, rd_ptr[ep_sel]}),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < NUM_EP; e++) begin
        rx_len[e] <= '0;
        rd_ptr[e] <= '0;
      end
      rx_full    <= '0;
      rx_eop     <= 1'b0;
      word_valid <= 1'b0;
      mask_q     <= '0;
      out_nak    <= 1'b0;
    end else begin
      rx_eop     <= done;
      word_valid <= hit;
      mask_q     <= tail_mask(rem_nb);
      if (abort) rd_ptr[ep_sel] <= '0;
      if (hit) begin
        rd_ptr[ep_sel] <= last ? '0 : rd_ptr[ep_sel] + 1'b1;
        if (last) rx_full[ep_sel] <= 1'b0;
      end
      if (frame_tick) rx_full <= rx_full & ~ISO_MASK;
      out_nak <= 1'b0;
      if (out_done) begin
        if (accept) begin
          rx_full[out_ep] <= 1'b1;
          rx_len[out_ep]  <= out_len;
          rd_ptr[out_ep]  <= '0;
        end else begin
          out_nak <= 1'b1;
        end
      end
    end
  end

  a_r9_nak_needs_done: assert property (@(posedge clk) disable iff (rst)
    out_nak |-> ($past(out_done) && !$past(rst)));
  a_r10_iso_never_nak: assert property (@(posedge clk) disable iff (rst)
    out_nak |-> !ISO_MASK[$past(out_ep)]);
endmodule

// File: rtl/usb_epbuf_port.sv
module usb_epbuf_port
  import usb_epbuf_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int PKT_WORDS = 16,
  parameter logic [NUM_EP-1:0] ISO_MASK = NUM_EP'(1) << (NUM_EP - 1),
  localparam int EPW  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int PTRW = $clog2(PKT_WORDS),
  localparam int LENW = $clog2(PKT_WORDS * 4 + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [1:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            tx_eop,
  output logic            rx_eop,
  input  logic            frame_tick,
  input  logic            val_req,
  input  logic [EPW-1:0]  val_ep,
  input  logic            in_req,
  input  logic [EPW-1:0]  in_ep,
  input  logic [PTRW-1:0] in_word_idx,
  output logic [31:0]     in_word,
  output logic            in_ack,
  output logic            in_nak,
  output logic [LENW-1:0] in_len,
  input  logic            out_wr,
  input  logic [EPW-1:0]  out_ep,
  input  logic [PTRW-1:0] out_word_idx,
  input  logic [31:0]     out_wdata,
  input  logic            out_done,
  input  logic [LENW-1:0] out_len,
  output logic            out_nak
);
  logic           rd_en_q, wr_en_q;
  logic [EPW-1:0] ep_q, new_ep;
  logic           ctrl_wr, cpu_rd, abort_wr, abort_rd;
  logic           tx_done, rx_done, rx_word_valid;
  logic [31:0]    rx_word, ctrl_rd_q;

  always_comb begin
    ctrl_wr  = reg_wr && reg_addr == RA_CTRL;
    cpu_rd   = reg_rd && !reg_wr;
    new_ep   = reg_wdata[2 +: EPW];
    abort_wr = ctrl_wr && wr_en_q && (!reg_wdata[1] || new_ep != ep_q);
    abort_rd = ctrl_wr && rd_en_q && (!reg_wdata[0] || new_ep != ep_q);
    reg_rdata = rx_word_valid ? rx_word : ctrl_rd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en_q   <= 1'b0;
      wr_en_q   <= 1'b0;
      ep_q      <= '0;
      ctrl_rd_q <= '0;
    end else begin
      if (ctrl_wr) begin
        rd_en_q <= reg_wdata[0];
        wr_en_q <= reg_wdata[1];
        ep_q    <= new_ep;
      end else begin
        if (tx_done) wr_en_q <= 1'b0;
        if (rx_done) rd_en_q <= 1'b0;
      end
      ctrl_rd_q <= (cpu_rd && reg_addr == RA_CTRL)
                   ? 32'({ep_q, wr_en_q, rd_en_q}) : '0;
    end
  end

  usb_epbuf_tx #(.NUM_EP(NUM_EP), .PKT_WORDS(PKT_WORDS), .ISO_MASK(ISO_MASK)) u_tx (
    .clk         (clk),
    .rst         (rst),
    .ep_sel      (ep_q),
    .wr_en       (wr_en_q),
    .abort       (abort_wr),
    .len_wr      (reg_wr && reg_addr == RA_TXLEN),
    .data_wr     (reg_wr && reg_addr == RA_TXDATA),
    .wdata       (reg_wdata),
    .done        (tx_done),
    .tx_eop      (tx_eop),
    .val_req     (val_req),
    .val_ep      (val_ep),
    .frame_tick  (frame_tick),
    .in_req      (in_req),
    .in_ep       (in_ep),
    .in_word_idx (in_word_idx),
    .in_word     (in_word),
    .in_ack      (in_ack),
    .in_nak      (in_nak),
    .in_len      (in_len)
  );

  usb_epbuf_rx #(.NUM_EP(NUM_EP), .PKT_WORDS(PKT_WORDS), .ISO_MASK(ISO_MASK)) u_rx (
    .clk          (clk),
    .rst          (rst),
    .ep_sel       (ep_q),
    .rd_en        (rd_en_q),
    .abort        (abort_rd),
    .data_rd      (cpu_rd && reg_addr == RA_RXDATA),
    .done         (rx_done),
    .rx_eop       (rx_eop),
    .word_valid   (rx_word_valid),
    .word         (rx_word),
    .frame_tick   (frame_tick),
    .out_wr       (out_wr),
    .out_ep       (out_ep),
    .out_word_idx (out_word_idx),
    .out_wdata    (out_wdata),
    .out_done     (out_done),
    .out_len      (out_len),
    .out_nak      (out_nak)
  );

  a_r2_eop_clears_wr: assert property (@(posedge clk) disable iff (rst)
    tx_eop |-> !wr_en_q);
  a_r4_eop_clears_rd: assert property (@(posedge clk) disable iff (rst)
    rx_eop |-> !rd_en_q);
  a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_rd) && $past(reg_addr) == RA_RXDATA && !$past(rd_en_q) && !$past(rst))
    |-> reg_rdata == '0);
endmodule

// File: tb/tb_usb_epbuf_port.sv
module tb_usb_epbuf_port;
  localparam int EPW = 2, PTRW = 4, LENW = 7;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic tx_eop, rx_eop, frame_tick = 0, val_req = 0;
  logic [EPW-1:0] val_ep = '0, in_ep = '0, out_ep = '0;
  logic in_req = 0, in_ack, in_nak, out_wr = 0, out_done = 0, out_nak;
  logic [PTRW-1:0] in_word_idx = '0, out_word_idx = '0;
  logic [31:0] in_word, out_wdata = '0;
  logic [LENW-1:0] in_len, out_len = '0;

  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  usb_epbuf_port dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_eop(tx_eop), .rx_eop(rx_eop),
    .frame_tick(frame_tick), .val_req(val_req), .val_ep(val_ep), .in_req(in_req),
    .in_ep(in_ep), .in_word_idx(in_word_idx), .in_word(in_word), .in_ack(in_ack),
    .in_nak(in_nak), .in_len(in_len), .out_wr(out_wr), .out_ep(out_ep),
    .out_word_idx(out_word_idx), .out_wdata(out_wdata), .out_done(out_done),
    .out_len(out_len), .out_nak(out_nak)
  );

  // {len[7:0], base word[31:0]}
  localparam logic [39:0] VEC [0:5] = '{
    {8'd1,  32'hA1B2C3D4}, {8'd2,  32'h11223344}, {8'd3,  32'hCAFE0100},
    {8'd4,  32'h0BAD0F00}, {8'd7,  32'h5A5A0000}, {8'd64, 32'h77000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] keep_bytes(input logic [31:0] w, input int nb);
    logic [31:0] r = '0;
    for (int b = 0; b < 4; b++) if (b < nb) r[8*b +: 8] = w[8*b +: 8];
    return r;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic load_out(input int ep, input int len, input logic [31:0] base, output logic nak);
    for (int i = 0; i < (len + 3) / 4; i++) begin
      out_wr = 1; out_ep = EPW'(ep); out_word_idx = PTRW'(i); out_wdata = base + 32'(i);
      @(negedge clk);
    end
    out_wr = 0; out_done = 1; out_ep = EPW'(ep); out_len = LENW'(len);
    @(negedge clk);
    out_done = 0;
    nak = out_nak;
  endtask

  task automatic inreq(input int ep);
    in_req = 1; in_ep = EPW'(ep);
    @(negedge clk);
    in_req = 0;
  endtask

  task automatic peek(input int ep, input int idx, output logic [31:0] d);
    in_ep = EPW'(ep); in_word_idx = PTRW'(idx);
    @(negedge clk);
    d = in_word;
  endtask

  task automatic validate(input int ep);
    val_req = 1; val_ep = EPW'(ep);
    @(negedge clk);
    val_req = 0;
  endtask

  task automatic tick();
    frame_tick = 1;
    @(negedge clk);
    frame_tick = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic nak;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata after reset", reg_rdata, 0);
    chk("R1 flags after reset", {tx_eop, rx_eop, in_ack, in_nak, out_nak}, 0);
    rd(0, d); chk("R1 ctrl after reset", d, 0);
    wr(0, 32'h6); rd(0, d); chk("R1 ctrl readback", d, 32'h6);
    wr(0, 0);

    // R4 table of receive packet lengths, endpoint 1
    for (int v = 0; v < 6; v++) begin
      int len = int'(VEC[v][39:32]);
      logic [31:0] base = VEC[v][31:0];
      load_out(1, len, base, nak);
      chk("R9 free buffer accepted", 32'(nak), 0);
      wr(0, 32'h5);
      for (int w = 0; w < (len + 3) / 4; w++) begin
        rd(3, d);
        chk("R4 rx word", d, keep_bytes(base + 32'(w), len - 4 * w));
        chk("R4 rx_eop timing", 32'(rx_eop), 32'(w == (len + 3) / 4 - 1));
      end
      rd(0, d); chk("R4 rd_en cleared", d, 32'h4);
    end

    // R2 transmit packet of 10 bytes on ep0
    wr(0, 32'h2); wr(1, 10);
    wr(2, 32'hA0A0A0A0); wr(2, 32'hB0B0B0B0);
    chk("R2 no early eop", 32'(tx_eop), 0);
    rd(0, d); chk("R2 wr_en held", d, 32'h2);
    wr(2, 32'hC0C0C0C0);
    chk("R2 tx_eop", 32'(tx_eop), 1);
    rd(0, d); chk("R2 wr_en cleared", d, 0);
    peek(0, 0, d); chk("R7 in_word 0", d, 32'hA0A0A0A0);
    peek(0, 2, d); chk("R7 in_word 2", d, 32'hC0C0C0C0);
    wr(0, 32'h6); wr(1, 0);
    chk("R2 zero length eop", 32'(tx_eop), 1);
    rd(0, d); chk("R2 zero length clears wr_en", d, 32'h4);
    wr(0, 32'h2); wr(1, 200);
    for (int i = 0; i < 15; i++) wr(2, 32'(i));
    chk("R2 clamp no eop before 16 words", 32'(tx_eop), 0);
    wr(2, 32'hF);
    chk("R2 clamp eop at 16 words", 32'(tx_eop), 1);
    wr(0, 32'h2); wr(1, 10);
    wr(2, 32'hA0A0A0A0); wr(2, 32'hB0B0B0B0); wr(2, 32'hC0C0C0C0);

    // R7 validate and send
    inreq(0); chk("R7 nak unvalidated", {31'd0, in_nak}, 1);
    validate(0);
    inreq(0); chk("R7 ack", {31'd0, in_ack}, 1); chk("R7 len", 32'(in_len), 10);
    inreq(0); chk("R7 nak after send", {31'd0, in_nak}, 1);

    // R3 abort restarts write
    wr(0, 32'h2); wr(1, 8); wr(2, 32'h1111_0000);
    wr(0, 0); wr(0, 32'h2); wr(2, 32'h2222_0000);
    peek(0, 0, d); chk("R3 restart at word 0", d, 32'h2222_0000);
    chk("R3 no eop", 32'(tx_eop), 0);
    wr(2, 32'h3333_0000);
    chk("R3 eop with kept length", 32'(tx_eop), 1);
    peek(0, 1, d); chk("R3 word 1", d, 32'h3333_0000);

    // R11 ignored accesses
    wr(0, 0); wr(2, 32'hDEAD_BEEF);
    chk("R11 no eop", 32'(tx_eop), 0);
    peek(0, 0, d); chk("R11 buffer untouched", d, 32'h2222_0000);
    wr(0, 32'h2); wr(2, 32'h4444_0000);
    peek(0, 0, d); chk("R11 position untouched", d, 32'h4444_0000);
    wr(0, 0);
    load_out(0, 4, 32'h9999_0000, nak);
    rd(3, d); chk("R11 read with rd_en low", d, 0);
    wr(0, 32'h1); rd(3, d); chk("R11 then packet intact", d, 32'h9999_0000);

    // R5 read abort keeps data
    load_out(2, 12, 32'h5000_0000, nak);
    wr(0, 32'h9);
    rd(3, d); rd(3, d); chk("R5 second word", d, 32'h5000_0001);
    wr(0, 0); wr(0, 32'h9);
    rd(3, d); chk("R5 restart at word 0", d, 32'h5000_0000);
    rd(3, d); rd(3, d); chk("R5 last word", d, 32'h5000_0002);
    chk("R5 eop", 32'(rx_eop), 1);

    // R9 full non-iso buffer
    load_out(1, 4, 32'hE100_0000, nak); chk("R9 accept", 32'(nak), 0);
    load_out(1, 4, 32'hE200_0000, nak); chk("R9 nak when full", 32'(nak), 1);
    wr(0, 32'h5); rd(3, d); chk("R9 old packet kept", d, 32'hE100_0000);

    // R6 interleaved on ep0
    load_out(0, 8, 32'h6600_0000, nak);
    wr(0, 32'h3); wr(1, 8);
    rd(3, d); chk("R6 read 0", d, 32'h6600_0000);
    wr(2, 32'h7700_0000);
    rd(3, d); chk("R6 read 1", d, 32'h6600_0001);
    chk("R6 rx eop", 32'(rx_eop), 1);
    rd(0, d); chk("R6 wr_en still set", d, 32'h2);
    wr(2, 32'h7700_0001);
    chk("R6 tx eop", 32'(tx_eop), 1);
    peek(0, 0, d); chk("R6 tx word 0", d, 32'h7700_0000);
    peek(0, 1, d); chk("R6 tx word 1", d, 32'h7700_0001);

    // R8 isochronous IN on ep3
    wr(0, 32'hE); wr(1, 6); wr(2, 32'h1); wr(2, 32'h2);
    validate(3);
    inreq(3); chk("R8 ack before frame", {31'd0, in_ack}, 1); chk("R8 empty packet", 32'(in_len), 0);
    tick();
    inreq(3); chk("R8 ack after frame", {31'd0, in_ack}, 1); chk("R8 full packet", 32'(in_len), 6);
    inreq(3); chk("R8 consumed", 32'(in_len), 0);
    chk("R8 no nak", {31'd0, in_nak}, 0);

    // R10 isochronous OUT on ep3
    load_out(3, 4, 32'hA100_0000, nak);
    load_out(3, 4, 32'hA200_0000, nak); chk("R10 no nak", 32'(nak), 0);
    wr(0, 32'hD); rd(3, d); chk("R10 overwrite", d, 32'hA200_0000);
    load_out(3, 4, 32'hA300_0000, nak);
    tick();
    wr(0, 32'hD); rd(3, d); chk("R10 frame discards", d, 0);

    summary();
    $finish;
  end
endmodule